// File: doc/BRIEF.md
# Periodic Link CRC Inserter

This block sits on the transmit side of a point-to-point packet link, between the flow source and the serialiser. Each dword it forwards carries two control flags: a low flag and a high flag. The block keeps a 32-bit CRC running over the payload dwords. The CRC covers all 34 bits of each transfer, so the flags are protected together with the data. The stream is split into windows of a fixed number of payload dwords.

When a window completes, its finished CRC is held. It is not sent at once. It goes out after a fixed number of payload dwords of the following window have passed. During the insertion cycle the block stalls the upstream source and sends the CRC dword with both flags set. The first window after reset or after a link restart has no predecessor, so nothing is inserted during it.

A force-error input damages the inserted value so that the far end's checker reports a mismatch. This lets the link's error path be exercised on purpose.

Top module: `crc_window_inserter`

## Requirements
- R1: While `rst` is high, `snk_valid_o` and `src_consume_o` are low. After reset the block behaves as in a first window.
- R2: When no CRC is due, the block passes the source straight through, combinationally in the same cycle. `snk_valid_o` equals `src_valid_i`, the dword and both flags are copied, and `src_consume_o` is `src_valid_i & snk_consume_i`.
- R3: No CRC dword is inserted until `WINDOW_LEN` payload dwords have been accepted since reset or restart.
- R4: Once a window completes, a CRC dword is presented with both flags high and `snk_valid_o` high. This happens as soon as exactly `CRC_OFFSET` payload dwords of the next window have been accepted, and before the next one.
- R5: The CRC is preset to all ones at each window start. For each payload dword it folds in, MSB-first with polynomial 0x04C11DB7, data bit 0 through data bit 31, then the low flag, then the high flag. The inserted value is the bitwise complement of the remainder at the window's end.
- R6: In any cycle where a CRC dword is presented, `src_consume_o` is low.
- R7: The window position advances only on accepted payload transfers (`src_consume_o` high). A CRC dword not consumed downstream is held unchanged in the following cycle.
- R8: While `force_err_i` is high, the inserted dword is the correct CRC with bit 0 inverted. Payload dwords are unaffected.
- R9: A `restart_i` pulse holds both handshake outputs low in that cycle. It clears the position, the running CRC and any owed CRC, returning to first-window behaviour.
- R10: With `src_valid_i` low and no CRC due, `snk_valid_o` is low. A due CRC is still sent without a source dword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart_i | input | 1 | Link restart pulse, synchronous clear |
| force_err_i | input | 1 | Corrupt the inserted CRC |
| src_valid_i | input | 1 | Source has a dword ready |
| src_dword_i | input | 32 | Source dword |
| src_lctl_i | input | 1 | Source low control flag |
| src_hctl_i | input | 1 | Source high control flag |
| src_consume_o | output | 1 | Source dword taken this cycle |
| snk_consume_i | input | 1 | Serialiser takes the presented dword |
| snk_valid_o | output | 1 | A dword is presented downstream |
| snk_dword_o | output | 32 | Presented dword |
| snk_lctl_o | output | 1 | Presented low control flag |
| snk_hctl_o | output | 1 | Presented high control flag |

## Verification
All outputs depend combinationally on the inputs and on the registered state. A stimulus applied in a cycle is therefore seen on the outputs in that same cycle. Its effect on the window position, the running CRC and the owed-CRC flag appears one edge later. The bench drives inputs just after the rising edge and compares outputs at the falling edge against a cycle model. It updates that model only for the transfer that the coming edge will complete. The CRC is due after exactly `CRC_OFFSET` accepted payload dwords, not a number of cycles. The model therefore counts accepted transfers under stalls, idle source cycles and restarts, using a small window so that many windows are crossed.

// File: rtl/crc_win_pkg.sv
package crc_win_pkg;
   localparam int DWORD_W = 32;
   localparam int CRC_W   = 32;
   localparam int FOLD_W  = DWORD_W + 2;

   typedef struct packed {
      logic               hctl;
      logic               lctl;
      logic [DWORD_W-1:0] dword;
   } flit_t;
endpackage

// File: rtl/crc_win_engine.sv
module crc_win_engine
   import crc_win_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             pay_acc,
   input  logic             win_end,
   input  flit_t            flit,
   output logic [CRC_W-1:0] crc_final
);
   localparam logic [CRC_W-1:0] PRESET = '1;

   logic [CRC_W-1:0]  crc_run;
   logic [FOLD_W-1:0] fold_bits;
   logic [CRC_W-1:0]  stage [0:FOLD_W];

   // bit 0..31 data, 32 low flag, 33 high flag
   assign fold_bits = flit;
   assign stage[0]  = crc_run;

   for (genvar g = 0; g < FOLD_W; g++) begin : g_fold
      logic fb;
      assign fb           = stage[g][CRC_W-1] ^ fold_bits[g];
      assign stage[g+1]   = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         crc_run   <= PRESET;
         crc_final <= '0;
      end else if (pay_acc) begin
         if (win_end) begin
            crc_final <= ~stage[FOLD_W];
            crc_run   <= PRESET;
         end else begin
            crc_run   <= stage[FOLD_W];
         end
      end
   end

   // R5
   preset_after_window_chk: assert property (@(posedge clk) disable iff (rst)
      (pay_acc && win_end && !clr) |=> (crc_run == PRESET));

   // R7
   crc_hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (!pay_acc && !clr) |=> $stable(crc_run));
endmodule

// File: rtl/crc_win_tracker.sv
module crc_win_tracker #(
   parameter int WINDOW_LEN = 128,
   parameter int CRC_OFFSET = 16
)(
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic pay_acc,
   input  logic crc_acc,
   output logic win_end,
   output logic crc_due
);
   localparam int POS_W = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WINDOW_LEN - 1);
   localparam logic [POS_W-1:0] INS_POS  = POS_W'(CRC_OFFSET);

   logic [POS_W-1:0] pos;
   logic             owed;

   assign win_end = pay_acc && (pos == LAST_POS);
   assign crc_due = owed && (pos == INS_POS);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         pos  <= '0;
         owed <= 1'b0;
      end else begin
         if (pay_acc) pos <= win_end ? '0 : pos + 1'b1;
         if (win_end)      owed <= 1'b1;
         else if (crc_acc) owed <= 1'b0;
      end
   end

   // R7
   pos_range_chk: assert property (@(posedge clk) disable iff (rst)
      pos <= LAST_POS);

   // R7
   pos_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (!pay_acc && !clr) |=> $stable(pos));

   // R6
   no_payload_while_due_chk: assert property (@(posedge clk) disable iff (rst)
      crc_due |-> !pay_acc);

   // R9
   restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> (!crc_due && pos == '0));

   // R7
   due_held_chk: assert property (@(posedge clk) disable iff (rst)
      (crc_due && !crc_acc && !clr) |=> crc_due);
endmodule

// File: rtl/crc_win_mux.sv
module crc_win_mux
   import crc_win_pkg::*;
#(
   parameter logic [CRC_W-1:0] ERR_MASK = 32'h1
)(
   input  logic             idle,
   input  logic             crc_due,
   input  logic             force_err,
   input  logic [CRC_W-1:0] crc_final,
   input  logic             src_valid,
   input  flit_t            src_flit,
   input  logic             snk_consume,
   output logic             src_consume,
   output logic             snk_valid,
   output flit_t            snk_flit,
   output logic             pay_acc,
   output logic             crc_acc
);
   logic ins;

   always_comb begin
      ins         = crc_due && !idle;
      snk_valid   = !idle && (ins || src_valid);
      src_consume = !idle && !ins && src_valid && snk_consume;
      pay_acc     = src_consume;
      crc_acc     = ins && snk_consume;
      if (ins) begin
         snk_flit.dword = crc_final ^ (force_err ? ERR_MASK : '0);
         snk_flit.lctl  = 1'b1;
         snk_flit.hctl  = 1'b1;
      end else begin
         snk_flit       = src_flit;
      end
   end
endmodule

// File: rtl/crc_window_inserter.sv
module crc_window_inserter
   import crc_win_pkg::*;
#(
   parameter int          WINDOW_LEN = 128,
   parameter int          CRC_OFFSET = 16,
   parameter logic [31:0] POLY       = 32'h04C11DB7,
   parameter logic [31:0] ERR_MASK   = 32'h1
)(
   input  logic        clk,
   input  logic        rst,
   input  logic        restart_i,
   input  logic        force_err_i,
   input  logic        src_valid_i,
   input  logic [31:0] src_dword_i,
   input  logic        src_lctl_i,
   input  logic        src_hctl_i,
   output logic        src_consume_o,
   input  logic        snk_consume_i,
   output logic        snk_valid_o,
   output logic [31:0] snk_dword_o,
   output logic        snk_lctl_o,
   output logic        snk_hctl_o
);
   if (WINDOW_LEN < 2) begin : g_bad_len
      $error("WINDOW_LEN must be at least 2");
   end
   if (CRC_OFFSET < 0 || CRC_OFFSET >= WINDOW_LEN) begin : g_bad_off
      $error("CRC_OFFSET must lie inside the window");
   end
   if (ERR_MASK == '0) begin : g_bad_mask
      $error("ERR_MASK must flip at least one bit");
   end

   logic             idle, pay_acc, crc_acc, win_end, crc_due;
   logic [CRC_W-1:0] crc_final;
   flit_t            src_flit, snk_flit;

   assign idle     = rst || restart_i;
   assign src_flit = '{hctl: src_hctl_i, lctl: src_lctl_i, dword: src_dword_i};

   crc_win_tracker #(.WINDOW_LEN(WINDOW_LEN), .CRC_OFFSET(CRC_OFFSET)) u_track (
      .clk(clk), .rst(rst), .clr(restart_i), .pay_acc(pay_acc),
      .crc_acc(crc_acc), .win_end(win_end), .crc_due(crc_due));

   crc_win_engine #(.POLY(POLY)) u_crc (
      .clk(clk), .rst(rst), .clr(restart_i), .pay_acc(pay_acc),
      .win_end(win_end), .flit(src_flit), .crc_final(crc_final));

   crc_win_mux #(.ERR_MASK(ERR_MASK)) u_mux (
      .idle(idle), .crc_due(crc_due), .force_err(force_err_i),
      .crc_final(crc_final), .src_valid(src_valid_i), .src_flit(src_flit),
      .snk_consume(snk_consume_i), .src_consume(src_consume_o),
      .snk_valid(snk_valid_o), .snk_flit(snk_flit), .pay_acc(pay_acc),
      .crc_acc(crc_acc));

   assign snk_dword_o = snk_flit.dword;
   assign snk_lctl_o  = snk_flit.lctl;
   assign snk_hctl_o  = snk_flit.hctl;

   // R6
   crc_blocks_source_chk: assert property (@(posedge clk) disable iff (rst)
      (crc_due && !restart_i) |-> !src_consume_o);

   // R4
   crc_flags_chk: assert property (@(posedge clk) disable iff (rst)
      (crc_due && !restart_i) |-> (snk_valid_o && snk_lctl_o && snk_hctl_o));

   // R9
   restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      restart_i |-> (!snk_valid_o && !src_consume_o));

   // R7
   crc_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (crc_due && !restart_i && !snk_consume_i) |=>
      (restart_i || !$stable(force_err_i) || $stable(snk_dword_o)));
endmodule

// File: tb/crc_window_inserter_test.sv
module crc_window_inserter_test;
   localparam int          WIN  = 8;
   localparam int          OFF  = 3;
   localparam logic [31:0] POLY = 32'h04C11DB7;
   localparam int          NCYC = 720;

   logic        clk = 1'b0;
   logic        rst = 1'b1, restart_i = 1'b0, force_err_i = 1'b0;
   logic        src_valid_i = 1'b0, src_lctl_i = 1'b0, src_hctl_i = 1'b0;
   logic [31:0] src_dword_i = '0;
   logic        snk_consume_i = 1'b0;
   logic        src_consume_o, snk_valid_o, snk_lctl_o, snk_hctl_o;
   logic [31:0] snk_dword_o;

   int checks = 0, failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   crc_window_inserter #(.WINDOW_LEN(WIN), .CRC_OFFSET(OFF)) uut (
      .clk(clk), .rst(rst), .restart_i(restart_i), .force_err_i(force_err_i),
      .src_valid_i(src_valid_i), .src_dword_i(src_dword_i),
      .src_lctl_i(src_lctl_i), .src_hctl_i(src_hctl_i),
      .src_consume_o(src_consume_o), .snk_consume_i(snk_consume_i),
      .snk_valid_o(snk_valid_o), .snk_dword_o(snk_dword_o),
      .snk_lctl_o(snk_lctl_o), .snk_hctl_o(snk_hctl_o));

   function automatic logic [31:0] ref_step(logic [31:0] c, logic [31:0] d,
                                            logic l, logic h);
      logic [33:0] v;
      v = {h, l, d};
      for (int i = 0; i < 34; i++) begin
         if (c[31] ^ v[i]) c = (c << 1) ^ POLY;
         else              c = c << 1;
      end
      return c;
   endfunction

   function automatic logic [31:0] word_of(int idx);
      return (32'(idx) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int          idx = 0;
      logic [15:0] lf = 16'hACE1;
      int          m_pos = 0;
      bit          m_pend = 0, m_first = 1, restarted = 0;
      logic [31:0] m_crc = '1, m_held = '0;
      bit          prev_ins_stall = 0, prev_force = 0;
      logic [31:0] prev_dword = '0;

      for (int c = 0; c < NCYC; c++) begin
         @(posedge clk);
         #1;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         rst       = (c < 3);
         restart_i = (c == 500) || (c == 611);
         if (c < 120) begin
            snk_consume_i = 1; src_valid_i = 1; force_err_i = 0;
         end else if (c < 360) begin
            snk_consume_i = lf[0] | lf[1]; src_valid_i = lf[2] | lf[3];
            force_err_i = 0;
         end else if (c < 480) begin
            snk_consume_i = 1; src_valid_i = lf[2]; force_err_i = 1;
         end else begin
            snk_consume_i = lf[4] | lf[5]; src_valid_i = 1;
            force_err_i = lf[9] & lf[11];
         end
         src_dword_i = word_of(idx);
         src_lctl_i  = idx[0];
         src_hctl_i  = idx[1] ^ idx[2];

         @(negedge clk);
         if (rst) begin
            // R1: reset holds the handshake outputs low
            chk(!snk_valid_o && !src_consume_o, "R1 reset outputs",
                {30'b0, snk_valid_o, src_consume_o}, '0);
         end else if (restart_i) begin
            // R9: restart cycle is quiet
            chk(!snk_valid_o && !src_consume_o, "R9 restart outputs",
                {30'b0, snk_valid_o, src_consume_o}, '0);
         end else begin
            bit          ins, exp_valid, exp_cons;
            logic [31:0] exp_dw;
            ins       = m_pend && (m_pos == OFF);
            exp_valid = ins || src_valid_i;
            exp_cons  = !ins && src_valid_i && snk_consume_i;
            chk(snk_valid_o == exp_valid,
                ins ? "R4 crc valid" : (src_valid_i ? "R2 valid" : "R10 idle source"),
                {31'b0, snk_valid_o}, {31'b0, exp_valid});
            chk(src_consume_o == exp_cons, ins ? "R6 consume low" : "R2 consume",
                {31'b0, src_consume_o}, {31'b0, exp_cons});
            if (ins) begin
               exp_dw = m_held ^ (force_err_i ? 32'h1 : 32'h0);
               chk(snk_dword_o == exp_dw, force_err_i ? "R8 forced crc" : "R5 crc value",
                   snk_dword_o, exp_dw);
               chk(snk_lctl_o && snk_hctl_o, "R4 crc flags",
                   {30'b0, snk_lctl_o, snk_hctl_o}, 32'h3);
               if (prev_ins_stall && prev_force == force_err_i)
                  // R7: stalled CRC dword held
                  chk(snk_dword_o == prev_dword, "R7 held crc", snk_dword_o, prev_dword);
            end else if (src_valid_i) begin
               chk(snk_dword_o == src_dword_i && snk_lctl_o == src_lctl_i &&
                   snk_hctl_o == src_hctl_i,
                   m_first ? (restarted ? "R9 payload after restart" : "R3 first window")
                           : (force_err_i ? "R8 payload untouched" : "R2 payload"),
                   snk_dword_o, src_dword_i);
            end
            prev_ins_stall = ins && !snk_consume_i;
            prev_force     = force_err_i;
            prev_dword     = snk_dword_o;
            if (ins && snk_consume_i) begin
               m_pend = 0;
            end else if (exp_cons) begin
               m_crc = ref_step(m_crc, src_dword_i, src_lctl_i, src_hctl_i);
               if (m_pos == WIN - 1) begin
                  m_held = ~m_crc; m_crc = '1; m_pos = 0; m_pend = 1; m_first = 0;
               end else begin
                  m_pos++;
               end
            end
         end
         if (rst || restart_i) begin
            m_pos = 0; m_pend = 0; m_first = 1; m_crc = '1; m_held = '0;
            prev_ins_stall = 0;
            if (restart_i) restarted = 1;
         end
         if (src_consume_o) idx++;
      end
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule